// File: doc/BRIEF.md
# I2C-Controlled Clock Steering Switch

This block is a write-only serial-bus target with a fixed 7-bit address. It has no register file. A controller addresses it, sends one data byte, and the lowest bit of that byte decides which of two downstream devices receives a host clock. The clock output that is not chosen is held low. An indicator output shows the current choice.

The bus lines are sampled with a faster system clock. Each line passes through a two-stage synchronizer, and the block then finds SCL edges and the START and STOP conditions. The block only ever pulls SDA low, using an output-enable pin, and it does this only in the two acknowledge slots of a transfer.

Top module: `i2c_clock_steer`

## Requirements
- R1: After a synchronous reset, the selection is 0, `sda_oe` is 0, `dev_a_clk` follows `host_clk`, and `dev_b_clk` is low.
- R2: When the first byte after START carries the address `DEV_ADDR` in bits 7..1 (sent MSB first) and a 0 (write) in bit 0, `sda_oe` is 1 while SCL is high during the ninth clock.
- R3: When the address does not match, no acknowledge is given for the address or for the byte that follows, and the selection is unchanged.
- R4: When the address matches but the R/W bit is 1 (read), no acknowledge is given and the selection is unchanged.
- R5: After a matched write address, the next data byte gets a second acknowledge: `sda_oe` is 1 while SCL is high during its ninth clock.
- R6: Bit 0 of the acknowledged data byte becomes the selection: 0 routes to device A and 1 routes to device B. Bits 7..1 are ignored.
- R7: The selection changes only once the data acknowledge clock has fallen; it keeps its old value during that clock. A STOP that arrives in the middle of the data byte leaves the selection unchanged.
- R8: The selected clock output follows `host_clk`. The other clock output stays low.
- R9: `sel_led` equals the current selection at all times.
- R10: `sda_oe` is 0 during every address and data bit. A STOP or a START releases it.
- R11: A repeated START, given at any point, restarts address reception. This holds even after a mismatched address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_clk | input | 1 | Clock to be steered |
| dev_a_clk | output | 1 | Clock output to device A |
| dev_b_clk | output | 1 | Clock output to device B |
| sel_led | output | 1 | Current selection, for an indicator |

## Verification
Two events land on the same system clock cycle: the SCL fall that ends the data acknowledge, and the update of the selection. On that one edge the block releases SDA and also loads bit 0. The bench samples inside the ninth clock's high phase and expects the acknowledge to be driven while the selection still holds its old value. It samples again after the fall and expects SDA released and the new value on `sel_led` and on the clock outputs. A STOP inserted halfway through a data byte checks the other side of this: the acknowledge never happens, so the selection must not move.

// File: rtl/i2c_steer_pkg.sv
package i2c_steer_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK_SET,
        ST_AACK,
        ST_DATA,
        ST_DACK_SET,
        ST_DACK,
        ST_WAIT
    } slv_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_evt_t;

    function automatic logic frame_hit(input logic [BYTE_W-1:0] frame,
                                       input logic [ADDR_W-1:0] own);
        return (frame[BYTE_W-1:1] == own) && !frame[0];
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_steer_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_chain[g] <= scl_in;
                    sda_chain[g] <= sda_in;
                end else begin
                    scl_chain[g] <= scl_chain[(g == 0) ? 0 : g-1];
                    sda_chain[g] <= sda_chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    logic scl_s, sda_s;
    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        evt.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_sel_slave.sv
module i2c_sel_slave
    import i2c_steer_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3A
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    output logic      sda_oe,
    output logic      sel
);

    slv_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] shifted;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    assign shifted = {shreg_q[BYTE_W-2:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            sda_oe  <= 1'b0;
            sel     <= 1'b0;
        end else if (evt.start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR: if (evt.scl_rise) begin
                    shreg_q <= shifted;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT)
                        state_q <= frame_hit(shifted, DEV_ADDR) ? ST_AACK_SET : ST_WAIT;
                end
                ST_AACK_SET: if (evt.scl_fall) begin
                    sda_oe  <= 1'b1;
                    state_q <= ST_AACK;
                end
                ST_AACK: if (evt.scl_fall) begin
                    sda_oe  <= 1'b0;
                    cnt_q   <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (evt.scl_rise) begin
                    shreg_q <= shifted;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT)
                        state_q <= ST_DACK_SET;
                end
                ST_DACK_SET: if (evt.scl_fall) begin
                    sda_oe  <= 1'b1;
                    state_q <= ST_DACK;
                end
                ST_DACK: if (evt.scl_fall) begin
                    sda_oe  <= 1'b0;
                    sel     <= shreg_q[0];
                    state_q <= ST_WAIT;
                end
                default: ;
            endcase
        end
    end

    // R10
    no_stray_drive_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state_q == ST_AACK || state_q == ST_DACK));

    // R7
    sel_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel) |-> ($past(state_q) == ST_DACK && $past(evt.scl_fall)));

    // R11
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state_q == ST_ADDR && cnt_q == '0 && !sda_oe));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !evt.start) |=> (state_q == ST_IDLE && !sda_oe));

endmodule

// File: rtl/clk_route.sv
module clk_route #(
    parameter int N_OUT = 2,
    localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clk,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] dev_clk
);

    genvar i;
    generate
        for (i = 0; i < N_OUT; i++) begin : g_out
            assign dev_clk[i] = host_clk & (sel == SEL_W'(i));
        end
    endgenerate

    // R8
    one_clock_live_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_clk));

endmodule

// File: rtl/i2c_clock_steer.sv
module i2c_clock_steer
    import i2c_steer_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h3A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic host_clk,
    output logic dev_a_clk,
    output logic dev_b_clk,
    output logic sel_led
);

    line_evt_t  evt;
    logic       sel;
    logic [1:0] dev_clk;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_sel_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sda_oe (sda_oe),
        .sel    (sel)
    );

    clk_route #(.N_OUT(2)) u_route (
        .clk      (clk),
        .rst      (rst),
        .host_clk (host_clk),
        .sel      (sel),
        .dev_clk  (dev_clk)
    );

    assign dev_a_clk = dev_clk[0];
    assign dev_b_clk = dev_clk[1];
    assign sel_led   = sel;

endmodule

// File: tb/i2c_clock_steer_bench.sv
module i2c_clock_steer_bench;

    localparam logic [6:0] OWN = 7'h3A;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic host_clk = 1'b0;
    logic sda_oe, dev_a_clk, dev_b_clk, sel_led;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    assign sda_line = sda_oe ? 1'b0 : sda_drv;

    always #2 clk = ~clk;
    always #7 host_clk = ~host_clk;

    i2c_clock_steer #(.DEV_ADDR(OWN)) u_i2c_clock_steer (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .host_clk(host_clk),
        .dev_a_clk(dev_a_clk), .dev_b_clk(dev_b_clk), .sel_led(sel_led)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1;     tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl = 1'b1;     tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; tick(Q);
        scl = 1'b1;  tick(Q);
        chk("R10 no drive in bit", {7'd0, sda_oe}, 8'd0);
        tick(Q);
        scl = 1'b0;  tick(Q);
    endtask

    // Sends a byte MSB first and returns the ack seen mid-high of clock 9
    // along with the selection at that same moment.
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic sel_mid);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1;     tick(Q);
        ack = sda_oe;
        sel_mid = sel_led;
        tick(Q);
        scl = 1'b0;     tick(Q);
    endtask

    task automatic check_route(input logic exp_sel, input string req);
        @(posedge host_clk); #1;
        chk(req, {6'd0, dev_b_clk, dev_a_clk}, exp_sel ? 8'h2 : 8'h1);
        @(negedge host_clk); #1;
        chk(req, {6'd0, dev_b_clk, dev_a_clk}, 8'h0);
        chk("R9 led", {7'd0, sel_led}, {7'd0, exp_sel});
    endtask

    task automatic do_write(input logic [6:0] a, input logic rw, input logic [7:0] d,
                            input logic exp_ack, input logic exp_sel, input string req);
        logic ack, mid, old;
        old = sel_led;
        bus_start();
        send_byte({a, rw}, ack, mid);
        chk({req, " addr ack"}, {7'd0, ack}, {7'd0, exp_ack});
        send_byte(d, ack, mid);
        chk({req, " data ack"}, {7'd0, ack}, {7'd0, exp_ack});
        chk("R7 old sel during ack", {7'd0, mid}, {7'd0, old});
        chk("R10 released after ack", {7'd0, sda_oe}, 8'd0);
        chk({req, " sel"}, {7'd0, sel_led}, {7'd0, exp_sel});
        bus_stop();
        chk("R10 idle after stop", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic t_reset();
        chk("R1 sel", {7'd0, sel_led}, 8'd0);
        chk("R1 oe", {7'd0, sda_oe}, 8'd0);
        check_route(1'b0, "R1 route");
    endtask

    task automatic t_select_b();
        do_write(OWN, 1'b0, 8'h01, 1'b1, 1'b1, "R2 R5 R6");
        check_route(1'b1, "R8 route B");
    endtask

    task automatic t_select_a();
        do_write(OWN, 1'b0, 8'hFE, 1'b1, 1'b0, "R6 high bits ignored");
        check_route(1'b0, "R8 route A");
    endtask

    task automatic t_wrong_addr();
        do_write(OWN ^ 7'h01, 1'b0, 8'h01, 1'b0, 1'b0, "R3 mismatch");
        check_route(1'b0, "R3 route");
    endtask

    task automatic t_read();
        do_write(OWN, 1'b1, 8'h01, 1'b0, 1'b0, "R4 read");
    endtask

    task automatic t_stop_mid();
        logic ack, mid;
        bus_start();
        send_byte({OWN, 1'b0}, ack, mid);
        chk("R2 ack before abort", {7'd0, ack}, 8'd1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk("R7 stop mid byte", {7'd0, sel_led}, 8'd0);
        check_route(1'b0, "R7 route");
    endtask

    task automatic t_rep_start();
        logic ack, mid;
        bus_start();
        send_byte({OWN ^ 7'h40, 1'b0}, ack, mid);
        chk("R11 first addr unacked", {7'd0, ack}, 8'd0);
        bus_start();
        send_byte({OWN, 1'b0}, ack, mid);
        chk("R11 restart addr ack", {7'd0, ack}, 8'd1);
        send_byte(8'h03, ack, mid);
        chk("R11 data ack", {7'd0, ack}, 8'd1);
        chk("R11 sel", {7'd0, sel_led}, 8'd1);
        bus_stop();
        check_route(1'b1, "R11 route");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(4);
        t_reset();
        t_select_b();
        t_select_a();
        t_wrong_addr();
        t_read();
        t_stop_mid();
        t_rep_start();
        finish_run();
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule